// File: doc/BRIEF.md
# Sample Pattern Checker with Interrupt Flags

This block watches a stream of I/Q sample pairs and compares every pair that arrives with a valid strobe against two expected words held in software-writable registers. A matching pair raises a latched pass flag. A mismatching pair raises two failure flags. One of them stays set until software clears it. The other drops by itself once a run of eight consecutive matching pairs has followed the last mismatch.

The same flag register also latches events from the neighbouring clocking and buffering logic. These are lock gained and lock lost for a PLL status level, the same two events for a sync status level, and two buffer warnings that fire when the write pointer leads the read pointer by one or by two entries. Each flag has an enable bit. The registered interrupt output is high whenever any enabled flag is set. Software clears a flag by writing 1 to its bit. When a hardware event arrives in the same cycle as that clear, the event takes precedence.

Top module: `sample_check_irq`

## Requirements
- R1: A pair is compared only in cycles where `smp_valid` is high. A pair equal to both expected words sets the pass flag (bit 6) at the next clock edge, and the flag stays set.
- R2: A compared pair that differs from either expected word sets the sticky fail flag (bit 8) at the next edge. Only a software clear removes it.
- R3: A compared mismatch also sets the self-clearing fail flag (bit 7). While that flag is set, it clears on the eighth consecutive matching pair after the last mismatch. A mismatch restarts the count.
- R4: A write to the flag register (address 3) clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R5: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R6: A rising edge of `pll_locked` sets bit 1 and a falling edge sets bit 0. A rising edge of `sync_locked` sets bit 3 and a falling edge sets bit 2. A lost flag is set only after the level has been seen high since reset.
- R7: Bit 4 is set while the write pointer minus the read pointer, taken modulo the pointer range, equals 1. Bit 5 is set while that difference equals 2.
- R8: The enable register (address 2) resets to 0. `irq` is a register. It updates at the same edge as the flags and enables, and equals the OR over all flags of flag AND enable.
- R9: The registers are expected I at address 0, expected Q at address 1, enables at address 2 and flags at address 3, all readable on `reg_rdata`. A write takes effect at the clock edge where `reg_wr` is high.
- R10: After reset all flags, enables, expected words and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_i | input | SAMPLE_W | Received I word |
| smp_q | input | SAMPLE_W | Received Q word |
| pll_locked | input | 1 | PLL lock status level |
| sync_locked | input | 1 | Sync alignment status level |
| fifo_wr_ptr | input | PTR_W | Buffer write pointer |
| fifo_rd_ptr | input | PTR_W | Buffer read pointer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | SAMPLE_W | Register write data |
| reg_rdata | output | SAMPLE_W | Register read data for reg_addr |
| irq | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a hardware flag set that lands in the same cycle as a software write-one-to-clear of that flag. The bench provokes it by driving a mismatching valid pair in the same cycle as a flag-register write with bits 7 and 8 high. Both fail flags must read back as set afterwards. The bench also crosses the self-clearing count with a mid-run mismatch, and it steps the pointer difference across the wrap of the pointer range.

// File: rtl/sample_check_irq_pkg.sv
package sample_check_irq_pkg;
    localparam int NFLAG       = 9;
    localparam int F_PLL_LOST  = 0;
    localparam int F_PLL_LOCK  = 1;
    localparam int F_SYN_LOST  = 2;
    localparam int F_SYN_LOCK  = 3;
    localparam int F_FIFO_D1   = 4;
    localparam int F_FIFO_D2   = 5;
    localparam int F_CMP_PASS  = 6;
    localparam int F_FAIL_AUTO = 7;
    localparam int F_FAIL_HOLD = 8;

    typedef enum logic [1:0] {
        RA_EXP_I = 2'd0,
        RA_EXP_Q = 2'd1,
        RA_EN    = 2'd2,
        RA_FLAGS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/sci_level_edge.sv
module sci_level_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = level;
        rise   = level & ~seen_q;
        fall   = ~level & seen_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end
endmodule

// File: rtl/sci_ptr_gap.sv
module sci_ptr_gap #(
    parameter int PTR_W = 4
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic             gap_one,
    output logic             gap_two
);
    logic [PTR_W-1:0] gap;

    always_comb begin
        gap     = wr_ptr - rd_ptr;
        gap_one = (gap == PTR_W'(1));
        gap_two = (gap == PTR_W'(2));
    end
endmodule

// File: rtl/sci_pair_cmp.sv
module sci_pair_cmp #(
    parameter int SAMPLE_W = 16
) (
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] got_i,
    input  logic [SAMPLE_W-1:0] got_q,
    input  logic [SAMPLE_W-1:0] want_i,
    input  logic [SAMPLE_W-1:0] want_q,
    output logic                hit,
    output logic                miss
);
    logic same;

    always_comb begin
        same = (got_i == want_i) && (got_q == want_q);
        hit  = valid & same;
        miss = valid & ~same;
    end
endmodule

// File: rtl/sample_check_irq.sv
module sample_check_irq
    import sample_check_irq_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int PTR_W      = 4,
    parameter int GOOD_PAIRS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] smp_q,
    input  logic                pll_locked,
    input  logic                sync_locked,
    input  logic [PTR_W-1:0]    fifo_wr_ptr,
    input  logic [PTR_W-1:0]    fifo_rd_ptr,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [SAMPLE_W-1:0] reg_wdata,
    output logic [SAMPLE_W-1:0] reg_rdata,
    output logic                irq
);
    localparam int CNT_W = $clog2(GOOD_PAIRS + 1);

    typedef struct packed {
        logic [NFLAG-1:0]    flags;
        logic [NFLAG-1:0]    en;
        logic [SAMPLE_W-1:0] exp_i;
        logic [SAMPLE_W-1:0] exp_q;
        logic [CNT_W-1:0]    good_cnt;
        logic                irq;
    } state_t;

    state_t s_d, s_q;

    logic pll_rise, pll_fall, syn_rise, syn_fall;
    logic gap_one, gap_two;
    logic pair_hit, pair_miss;

    sci_level_edge u_pll_edge (
        .clk(clk), .rst_n(rst_n), .level(pll_locked),
        .rise(pll_rise), .fall(pll_fall)
    );

    sci_level_edge u_syn_edge (
        .clk(clk), .rst_n(rst_n), .level(sync_locked),
        .rise(syn_rise), .fall(syn_fall)
    );

    sci_ptr_gap #(.PTR_W(PTR_W)) u_gap (
        .wr_ptr(fifo_wr_ptr), .rd_ptr(fifo_rd_ptr),
        .gap_one(gap_one), .gap_two(gap_two)
    );

    sci_pair_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
        .valid(smp_valid), .got_i(smp_i), .got_q(smp_q),
        .want_i(s_q.exp_i), .want_q(s_q.exp_q),
        .hit(pair_hit), .miss(pair_miss)
    );

    logic [NFLAG-1:0] hw_set, sw_clr, auto_drop;

    always_comb begin
        s_d = s_q;

        hw_set              = '0;
        hw_set[F_PLL_LOST]  = pll_fall;
        hw_set[F_PLL_LOCK]  = pll_rise;
        hw_set[F_SYN_LOST]  = syn_fall;
        hw_set[F_SYN_LOCK]  = syn_rise;
        hw_set[F_FIFO_D1]   = gap_one;
        hw_set[F_FIFO_D2]   = gap_two;
        hw_set[F_CMP_PASS]  = pair_hit;
        hw_set[F_FAIL_AUTO] = pair_miss;
        hw_set[F_FAIL_HOLD] = pair_miss;

        sw_clr = (reg_wr && reg_addr == RA_FLAGS) ? reg_wdata[NFLAG-1:0] : '0;

        auto_drop = '0;
        if (pair_miss) begin
            s_d.good_cnt = '0;
        end else if (pair_hit && s_q.flags[F_FAIL_AUTO]) begin
            if (s_q.good_cnt == CNT_W'(GOOD_PAIRS - 1)) begin
                auto_drop[F_FAIL_AUTO] = 1'b1;
                s_d.good_cnt           = '0;
            end else begin
                s_d.good_cnt = s_q.good_cnt + CNT_W'(1);
            end
        end
        if (sw_clr[F_FAIL_AUTO] && !pair_miss) begin
            s_d.good_cnt = '0;
        end

        s_d.flags = (s_q.flags & ~sw_clr & ~auto_drop) | hw_set;

        if (reg_wr) begin
            case (reg_addr)
                RA_EXP_I: s_d.exp_i = reg_wdata;
                RA_EXP_Q: s_d.exp_q = reg_wdata;
                RA_EN:    s_d.en    = reg_wdata[NFLAG-1:0];
                default:  ;
            endcase
        end

        s_d.irq = |(s_d.flags & s_d.en);

        case (reg_addr)
            RA_EXP_I: reg_rdata = s_q.exp_i;
            RA_EXP_Q: reg_rdata = s_q.exp_q;
            RA_EN:    reg_rdata = SAMPLE_W'(s_q.en);
            default:  reg_rdata = SAMPLE_W'(s_q.flags);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

    logic [NFLAG-1:0]    flags_w, en_w;
    logic [SAMPLE_W-1:0] exp_i_w, exp_q_w;
    assign flags_w = s_q.flags;
    assign en_w    = s_q.en;
    assign exp_i_w = s_q.exp_i;
    assign exp_q_w = s_q.exp_q;
endmodule

// File: rtl/sample_check_irq_chk.sv
module sample_check_irq_chk
    import sample_check_irq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int PTR_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_i,
    input logic [SAMPLE_W-1:0] smp_q,
    input logic                pll_locked,
    input logic [PTR_W-1:0]    fifo_wr_ptr,
    input logic [PTR_W-1:0]    fifo_rd_ptr,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic [SAMPLE_W-1:0] reg_wdata,
    input logic [NFLAG-1:0]    flags,
    input logic [NFLAG-1:0]    en,
    input logic [SAMPLE_W-1:0] exp_i,
    input logic [SAMPLE_W-1:0] exp_q,
    input logic                irq
);
    logic good, bad, flag_wr;
    logic [PTR_W-1:0] lead;
    always_comb begin
        good    = smp_valid && smp_i == exp_i && smp_q == exp_q;
        bad     = smp_valid && !(smp_i == exp_i && smp_q == exp_q);
        flag_wr = reg_wr && reg_addr == 2'd3;
        lead    = fifo_wr_ptr - fifo_rd_ptr;
    end

    assert_pass_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> flags[F_CMP_PASS]);

    assert_hold_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> flags[F_FAIL_HOLD]);

    assert_auto_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[F_FAIL_AUTO]) |-> ($past(good) || $past(flag_wr && reg_wdata[F_FAIL_AUTO])));

    assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !reg_wdata[F_FAIL_HOLD] && flags[F_FAIL_HOLD]) |=> flags[F_FAIL_HOLD]);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bad && flag_wr && reg_wdata[F_FAIL_AUTO]) |=> flags[F_FAIL_AUTO]);

    assert_lost_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_PLL_LOST]) |-> ($past(pll_locked, 2) && !$past(pll_locked)));

    assert_gap_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lead == PTR_W'(1)) |=> flags[F_FIFO_D1]);

    assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(flags & en));
endmodule

bind sample_check_irq sample_check_irq_chk #(.SAMPLE_W(SAMPLE_W), .PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .pll_locked(pll_locked), .fifo_wr_ptr(fifo_wr_ptr), .fifo_rd_ptr(fifo_rd_ptr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flags(flags_w), .en(en_w), .exp_i(exp_i_w), .exp_q(exp_q_w), .irq(irq)
);

// File: tb/sample_check_irq_test.sv
module sample_check_irq_test;
    localparam int CLK_NS = 10;
    localparam int SW = 16;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_i = '0, smp_q = '0;
    logic          pll_locked = 1'b0, sync_locked = 1'b0;
    logic [PW-1:0] fifo_wr_ptr = '0, fifo_rd_ptr = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd3;
    logic [SW-1:0] reg_wdata = '0;
    logic [SW-1:0] reg_rdata;
    logic          irq;

    int checks = 0, failures = 0;
    bit finished = 0;

    localparam logic [SW-1:0] EI = 16'h1234, EQ = 16'hABCD;

    always #(CLK_NS/2) clk = ~clk;

    sample_check_irq uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .pll_locked(pll_locked), .sync_locked(sync_locked),
        .fifo_wr_ptr(fifo_wr_ptr), .fifo_rd_ptr(fifo_rd_ptr),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [SW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [SW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd3;
    endtask

    task automatic send(input logic v, input logic [SW-1:0] i, input logic [SW-1:0] q);
        smp_valid = v; smp_i = i; smp_q = q;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [SW-1:0] d;
        rd_reg(2'd3, d); chk("R10 flags after reset", d, '0);
        rd_reg(2'd2, d); chk("R8 enables after reset", d, '0);
        rd_reg(2'd0, d); chk("R10 expected I after reset", d, '0);
        chk("R10 irq after reset", SW'(irq), '0);
    endtask

    task automatic t_pass;
        logic [SW-1:0] d;
        wr_reg(2'd0, EI); wr_reg(2'd1, EQ);
        rd_reg(2'd0, d); chk("R9 expected I readback", d, EI);
        rd_reg(2'd1, d); chk("R9 expected Q readback", d, EQ);
        send(1'b0, 16'h0, 16'h0);
        rd_reg(2'd3, d); chk("R1 no compare without valid", d, '0);
        send(1'b1, EI, EQ);
        rd_reg(2'd3, d); chk("R1 pass flag on match", d, 16'h040);
        @(negedge clk);
        rd_reg(2'd3, d); chk("R1 pass flag latched", d, 16'h040);
    endtask

    task automatic t_fail;
        logic [SW-1:0] d;
        send(1'b1, EI, EQ ^ 16'h0001);
        rd_reg(2'd3, d); chk("R2 both fail flags on Q mismatch", d, 16'h1C0);
        wr_reg(2'd3, 16'h040);
        repeat (3) @(negedge clk);
        rd_reg(2'd3, d); chk("R2 sticky fail stays", d, 16'h180);
    endtask

    task automatic t_auto;
        logic [SW-1:0] d;
        for (int k = 0; k < 5; k++) send(1'b1, EI, EQ);
        send(1'b1, EI ^ 16'h8000, EQ);
        for (int k = 0; k < 7; k++) send(1'b1, EI, EQ);
        rd_reg(2'd3, d); chk("R3 auto fail held after 7 good", d & 16'h180, 16'h180);
        send(1'b1, EI, EQ);
        rd_reg(2'd3, d); chk("R3 auto fail cleared on 8th good", d & 16'h180, 16'h100);
    endtask

    task automatic t_w1c;
        logic [SW-1:0] d;
        wr_reg(2'd3, 16'h000);
        rd_reg(2'd3, d); chk("R4 zero write keeps flags", d, 16'h140);
        wr_reg(2'd3, 16'h040);
        rd_reg(2'd3, d); chk("R4 clear pass only", d, 16'h100);
        wr_reg(2'd3, 16'h100);
        rd_reg(2'd3, d); chk("R4 clear sticky", d, 16'h000);
    endtask

    task automatic t_collide;
        logic [SW-1:0] d;
        smp_valid = 1'b1; smp_i = 16'h0; smp_q = 16'h0;
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h180;
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
        rd_reg(2'd3, d); chk("R5 set wins over clear", d, 16'h180);
        wr_reg(2'd3, 16'h1FF);
        rd_reg(2'd3, d); chk("R4 clear all", d, 16'h000);
    endtask

    task automatic t_lock;
        logic [SW-1:0] d;
        repeat (3) @(negedge clk);
        rd_reg(2'd3, d); chk("R6 no lost without prior lock", d, 16'h000);
        pll_locked = 1'b1; @(negedge clk);
        rd_reg(2'd3, d); chk("R6 pll locked rise", d, 16'h002);
        pll_locked = 1'b0; @(negedge clk);
        rd_reg(2'd3, d); chk("R6 pll lost after lock", d, 16'h003);
        sync_locked = 1'b1; @(negedge clk);
        sync_locked = 1'b0; @(negedge clk);
        rd_reg(2'd3, d); chk("R6 sync locked and lost", d, 16'h00F);
        wr_reg(2'd3, 16'h00F);
        rd_reg(2'd3, d); chk("R6 lock flags cleared", d, 16'h000);
    endtask

    task automatic t_fifo;
        logic [SW-1:0] d;
        fifo_wr_ptr = 4'd5; fifo_rd_ptr = 4'd4; @(negedge clk);
        rd_reg(2'd3, d); chk("R7 gap of one", d, 16'h010);
        fifo_wr_ptr = 4'd6; @(negedge clk);
        rd_reg(2'd3, d); chk("R7 gap of two", d, 16'h030);
        fifo_rd_ptr = 4'd3; @(negedge clk);
        wr_reg(2'd3, 16'h030);
        rd_reg(2'd3, d); chk("R7 gap of three sets nothing", d, 16'h000);
        fifo_wr_ptr = 4'd0; fifo_rd_ptr = 4'd15; @(negedge clk);
        rd_reg(2'd3, d); chk("R7 gap of one across wrap", d, 16'h010);
        fifo_wr_ptr = 4'd0; fifo_rd_ptr = 4'd0; @(negedge clk);
        wr_reg(2'd3, 16'h030);
    endtask

    task automatic t_irq;
        logic [SW-1:0] d;
        send(1'b1, EI, EQ);
        chk("R8 no irq while disabled", SW'(irq), '0);
        wr_reg(2'd2, 16'h040);
        rd_reg(2'd2, d); chk("R9 enable readback", d, 16'h040);
        chk("R8 irq with enabled flag", SW'(irq), 16'h1);
        wr_reg(2'd2, 16'h100);
        chk("R8 irq masked by enable", SW'(irq), '0);
        wr_reg(2'd2, 16'h040);
        wr_reg(2'd3, 16'h040);
        chk("R8 irq drops on clear", SW'(irq), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_fail();
        t_auto();
        t_w1c();
        t_collide();
        t_lock();
        t_fifo();
        t_irq();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule